// File: doc/BRIEF.md
# High-Speed Hub Repeater Direction Controller

This block decides, in a high-speed hub, whether the repeater currently carries traffic away from the host, toward the host, or nothing at all. It follows the microframe. After reset, and at every microframe end, it only accepts a packet start from the upstream port. Once the hub is locked to frame-start timing, it also accepts packet starts from any downstream port between upstream packets.

Its event inputs are single-cycle pulses that come from logic outside the block:
- Start events arrive only after the packet validator has accepted a sync pattern.
- End events arrive only after the last buffered bit has left the elasticity buffer.
- The two end-of-frame markers come from the frame timer.

The block therefore holds no data path. It runs a four-state controller and records which downstream port holds upstream connectivity. If that port is still sending when the late end-of-frame marker arrives, the block emits a one-cycle disable pulse that carries the port number.

Top module: `hub_rptr_ctrl`

## Requirements
- R1: After reset is released, `dir_o` is idle (2'b00), `port_dis_o` is low, and only an upstream start is accepted.
- R2: An upstream start (`sop_up_i`) seen while the controller waits for any start or for an upstream start makes `dir_o` downstream-bound (2'b01) on the next cycle. This does not happen if an end-of-frame marker outranks the start that cycle.
- R3: An upstream end (`eop_up_i`) during an upstream packet makes `dir_o` idle. With `sof_lock_i` high, the controller then accepts downstream starts. With `sof_lock_i` low, it accepts only an upstream start.
- R4: A downstream start (`sop_dn_i`) while any start is accepted makes `dir_o` upstream-bound (2'b10) and records `dn_port_i`.
- R5: A downstream end (`eop_dn_i`) during a downstream packet makes `dir_o` idle and re-enables starts from either direction, with no disable pulse.
- R6: `eof1_i` while any start is accepted makes the controller accept only an upstream start.
- R7: `eof2_i` during a downstream packet makes `dir_o` idle and raises `port_dis_o` for exactly one cycle. In that cycle `port_dis_id_o` equals the port recorded at that packet's start.
- R8: `eof2_i` in any state makes the controller accept only an upstream start. When it falls in the same cycle as an end event, `eof2_i` wins. The disable pulse of R7 is still produced.
- R9: `eof1_i` during an upstream or a downstream packet has no effect on `dir_o`.
- R10: A downstream start is ignored while the controller waits for an upstream start or carries an upstream packet. An upstream start outranks a downstream start in the same cycle.
- R11: `dir_o` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Hub transmit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sop_up_i | input | 1 | Validated start from upstream port |
| eop_up_i | input | 1 | Upstream packet fully repeated |
| sop_dn_i | input | 1 | Validated start from a downstream port |
| eop_dn_i | input | 1 | Downstream packet fully repeated |
| dn_port_i | input | PORT_W | Downstream port raising `sop_dn_i` |
| eof1_i | input | 1 | First end-of-frame marker |
| eof2_i | input | 1 | Second end-of-frame marker |
| sof_lock_i | input | 1 | Hub locked to frame-start timing |
| dir_o | output | 2 | 00 idle, 01 downstream-bound, 10 upstream-bound |
| port_dis_o | output | 1 | One-cycle disable pulse |
| port_dis_id_o | output | PORT_W | Port to disable, valid with `port_dis_o` |

## Verification
Two functions can land in one cycle: a packet end from either direction, and the late end-of-frame marker.

The bench raises `eof2_i` together with `eop_dn_i` during a downstream packet. It expects an idle direction and a disable pulse carrying the recorded port. It then gives a downstream start that must be ignored, which shows that the controller re-armed for an upstream start.

The bench also raises `eof2_i` together with a locked `eop_up_i`. It judges the result the same way: a following downstream start must leave `dir_o` idle.

// File: rtl/hub_rptr_pkg.sv
package hub_rptr_pkg;

  typedef enum logic [1:0] {
    ST_WSOP_UP = 2'd0,  // accept upstream start only
    ST_WEOP_UP = 2'd1,  // carrying upstream packet
    ST_WSOP    = 2'd2,  // accept start from either side
    ST_WEOP_DN = 2'd3   // carrying downstream packet
  } rptr_st_e;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'b00,
    DIR_DN   = 2'b01,
    DIR_UP   = 2'b10
  } rptr_dir_e;

endpackage

// File: rtl/rptr_next_state.sv
module rptr_next_state
  import hub_rptr_pkg::*;
(
  input  rptr_st_e st_i,
  input  logic     sop_up_i,
  input  logic     eop_up_i,
  input  logic     sop_dn_i,
  input  logic     eop_dn_i,
  input  logic     eof1_i,
  input  logic     eof2_i,
  input  logic     sof_lock_i,
  output rptr_st_e st_nxt_o,
  output logic     capture_o,
  output logic     fire_o
);

  always_comb begin
    st_nxt_o  = st_i;
    capture_o = 1'b0;
    fire_o    = 1'b0;
    unique case (st_i)
      ST_WSOP_UP: begin
        if (!eof2_i && sop_up_i) st_nxt_o = ST_WEOP_UP;
      end
      ST_WEOP_UP: begin
        if (eof2_i)        st_nxt_o = ST_WSOP_UP;
        else if (eop_up_i) st_nxt_o = sof_lock_i ? ST_WSOP : ST_WSOP_UP;
      end
      ST_WSOP: begin
        if (eof2_i || eof1_i) st_nxt_o = ST_WSOP_UP;
        else if (sop_up_i)    st_nxt_o = ST_WEOP_UP;
        else if (sop_dn_i) begin
          st_nxt_o  = ST_WEOP_DN;
          capture_o = 1'b1;
        end
      end
      ST_WEOP_DN: begin
        if (eof2_i) begin
          st_nxt_o = ST_WSOP_UP;
          fire_o   = 1'b1;
        end else if (eop_dn_i) st_nxt_o = ST_WSOP;
      end
      default: st_nxt_o = ST_WSOP_UP;
    endcase
  end

endmodule

// File: rtl/rptr_port_track.sv
module rptr_port_track #(
  parameter int unsigned PORT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              fire_i,
  output logic              dis_o,
  output logic [PORT_W-1:0] dis_id_o
);

  logic [PORT_W-1:0] port_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_q   <= '0;
      dis_o    <= 1'b0;
      dis_id_o <= '0;
    end else begin
      if (capture_i) port_q <= port_i;
      dis_o <= fire_i;
      if (fire_i) dis_id_o <= port_q;
    end
  end

  // R7: pulse lasts one cycle
  p_dis_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_o |=> !dis_o);

  // R7: pulse carries recorded port
  p_dis_port_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> (dis_o && dis_id_o == $past(port_q)));

endmodule

// File: rtl/hub_rptr_ctrl.sv
module hub_rptr_ctrl
  import hub_rptr_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sop_up_i,
  input  logic              eop_up_i,
  input  logic              sop_dn_i,
  input  logic              eop_dn_i,
  input  logic [PORT_W-1:0] dn_port_i,
  input  logic              eof1_i,
  input  logic              eof2_i,
  input  logic              sof_lock_i,
  output logic [1:0]        dir_o,
  output logic              port_dis_o,
  output logic [PORT_W-1:0] port_dis_id_o
);

  rptr_st_e st_q, st_nxt;
  logic     capture, fire;

  rptr_next_state u_nxt (
    .st_i      (st_q),
    .sop_up_i  (sop_up_i),
    .eop_up_i  (eop_up_i),
    .sop_dn_i  (sop_dn_i),
    .eop_dn_i  (eop_dn_i),
    .eof1_i    (eof1_i),
    .eof2_i    (eof2_i),
    .sof_lock_i(sof_lock_i),
    .st_nxt_o  (st_nxt),
    .capture_o (capture),
    .fire_o    (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_WSOP_UP;
    else         st_q <= st_nxt;
  end

  rptr_port_track #(.PORT_W(PORT_W)) u_port (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .port_i   (dn_port_i),
    .fire_i   (fire),
    .dis_o    (port_dis_o),
    .dis_id_o (port_dis_id_o)
  );

  always_comb begin
    unique case (st_q)
      ST_WEOP_UP: dir_o = DIR_DN;
      ST_WEOP_DN: dir_o = DIR_UP;
      default:    dir_o = DIR_IDLE;
    endcase
  end

  p_dir_legal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_o != 2'b11);

  p_sop_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WSOP_UP && sop_up_i && !eof2_i) |=> dir_o == DIR_DN);

  p_eop_dn_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WEOP_DN && eop_dn_i && !eof2_i) |=> (st_q == ST_WSOP && !port_dis_o));

  p_eof2_rearm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof2_i |=> st_q == ST_WSOP_UP);

  p_eof1_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WEOP_UP && eof1_i && !eof2_i && !eop_up_i) |=> dir_o == DIR_DN);

endmodule

// File: tb/hub_rptr_ctrl_test.sv
module hub_rptr_ctrl_test;

  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sop_up = 0, eop_up = 0, sop_dn = 0, eop_dn = 0;
  logic eof1 = 0, eof2 = 0, lock = 0;
  logic [PW-1:0] port = '0;
  logic [1:0] dir;
  logic dis;
  logic [PW-1:0] dis_id;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  hub_rptr_ctrl #(.NUM_PORTS(4)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .sop_up_i(sop_up), .eop_up_i(eop_up),
    .sop_dn_i(sop_dn), .eop_dn_i(eop_dn),
    .dn_port_i(port), .eof1_i(eof1), .eof2_i(eof2),
    .sof_lock_i(lock),
    .dir_o(dir), .port_dis_o(dis), .port_dis_id_o(dis_id)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ev bits: {eof2,eof1,eop_dn,sop_dn,eop_up,sop_up}
  task automatic go(input logic [5:0] ev, input logic lk, input logic [PW-1:0] p);
    @(negedge clk);
    {eof2, eof1, eop_dn, sop_dn, eop_up, sop_up} = ev;
    lock = lk;
    port = p;
    @(posedge clk);
    #1;
    {eof2, eof1, eop_dn, sop_dn, eop_up, sop_up} = '0;
    chk("R11 dir legal", int'(dir == 2'b11), 0);
  endtask

  localparam logic [5:0] E_SU = 6'b000001, E_EU = 6'b000010, E_SD = 6'b000100,
                         E_ED = 6'b001000, E_F1 = 6'b010000, E_F2 = 6'b100000,
                         E_NO = 6'b000000;

  task automatic t_reset();
    chk("R1 dir after reset", dir, 0);
    chk("R1 no pulse after reset", dis, 0);
    go(E_SD, 1, 2'd1);
    chk("R1 downstream start ignored after reset", dir, 0);
  endtask

  task automatic t_locked_cycle();
    go(E_SU, 1, 0);
    chk("R2 upstream start", dir, 1);
    go(E_EU, 1, 0);
    chk("R3 upstream end locked", dir, 0);
    go(E_SD, 1, 2'd3);
    chk("R4 downstream start", dir, 2);
    go(E_ED, 1, 0);
    chk("R5 downstream end dir", dir, 0);
    chk("R5 no pulse", dis, 0);
  endtask

  task automatic t_unlocked();
    go(E_SU, 0, 0);
    chk("R2 upstream start from wait-any", dir, 1);
    go(E_EU, 0, 0);
    chk("R3 upstream end unlocked", dir, 0);
    go(E_SD, 0, 2'd2);
    chk("R3 unlocked ignores downstream start", dir, 0);
  endtask

  task automatic t_eof1();
    go(E_SU, 1, 0);
    go(E_EU, 1, 0);
    go(E_F1, 1, 0);
    chk("R6 eof1 dir", dir, 0);
    go(E_SD, 1, 2'd1);
    chk("R6 downstream start ignored after eof1", dir, 0);
  endtask

  task automatic t_eof1_hold();
    go(E_SU, 1, 0);
    go(E_F1, 1, 0);
    chk("R9 eof1 in upstream packet", dir, 1);
    go(E_SD, 1, 2'd0);
    chk("R10 downstream start ignored in upstream packet", dir, 1);
    go(E_EU, 1, 0);
    go(E_SD, 1, 2'd1);
    go(E_F1, 1, 0);
    chk("R9 eof1 in downstream packet", dir, 2);
  endtask

  task automatic t_eof2_dn();
    // in downstream packet from port 1
    go(E_F2, 1, 0);
    chk("R7 eof2 dir", dir, 0);
    chk("R7 pulse", dis, 1);
    chk("R7 port id", dis_id, 1);
    go(E_NO, 1, 0);
    chk("R7 pulse one cycle", dis, 0);
    go(E_SD, 1, 2'd2);
    chk("R8 rearm after eof2", dir, 0);
  endtask

  task automatic t_eof2_prio();
    go(E_SU, 1, 0);
    go(E_EU, 1, 0);
    go(E_SD, 1, 2'd2);
    go(E_F2 | E_ED, 1, 0);
    chk("R8 eof2 beats eop_dn pulse", dis, 1);
    chk("R8 eof2 beats eop_dn id", dis_id, 2);
    chk("R8 eof2 beats eop_dn dir", dir, 0);
    go(E_SD, 1, 2'd0);
    chk("R8 rearmed after tie", dir, 0);
    go(E_SU, 1, 0);
    go(E_F2 | E_EU, 1, 0);
    chk("R8 eof2 beats eop_up dir", dir, 0);
    chk("R8 no pulse on upstream", dis, 0);
    go(E_SD, 1, 2'd3);
    chk("R8 rearmed after upstream tie", dir, 0);
  endtask

  task automatic t_both_sop();
    go(E_SU, 1, 0);
    go(E_EU, 1, 0);
    go(E_SU | E_SD, 1, 2'd1);
    chk("R10 upstream start wins", dir, 1);
    go(E_EU, 1, 0);
    chk("R3 end after tie", dir, 0);
  endtask

  initial begin : wdog
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_locked_cycle();
    t_unlocked();
    t_eof1();
    t_eof1_hold();
    t_eof2_dn();
    t_eof2_prio();
    t_both_sop();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule